// File: doc/BRIEF.md
# Register Port and ALU Operand Selector

This block sits between instruction fetch and the register file of a simple sequential 64-bit processor. Each cycle it takes the opcode, function code, two register fields and the evaluated branch/move condition of the instruction in flight. From these it chooses which registers the two read ports fetch and which registers the two write ports update. One write port carries the ALU result and the other carries the loaded memory value. It also tells the ALU what its two operands are and which operation to apply.

The stack pointer (register index 4) is substituted on its own for the stack instructions. The register index 15 on any port means "no access". A conditional move whose condition fails loses its write port. The selections are captured in one output register stage, so the register file and ALU of the next stage see stable control words for a whole cycle. A cycle with no valid instruction presents an idle control word.

Opcode encoding used throughout: 0 halt, 1 nop, 2 register/conditional move, 3 immediate-to-register move, 4 register-to-memory store, 5 memory-to-register load, 6 arithmetic, 7 jump, 8 call, 9 return, 10 push, 11 pop; 12 to 15 are unused. ALU operand-A codes: 0 read value A, 1 instruction constant, 2 constant +8, 3 constant -8. Operand-B codes: 0 read value B, 1 constant zero. Function codes: 0 add, 1 subtract, 2 and, 3 xor.

Top module: `rsel_top`

## Requirements
- R1: While rst_n is low at a rising edge, the next outputs are out_valid=0, src_a=src_b=dst_e=dst_m=15, alu_a_sel=0, alu_b_sel=1, alu_fn=0 (add) and set_cc=0.
- R2: Outputs present the selection for the inputs sampled at the previous rising edge. A cycle with in_valid low yields out_valid=0 and the idle word of R1.
- R3: Opcode 2 gives src_a=ra, src_b=15, operand A code 0, operand B code 1 (zero), add, dst_m=15. dst_e=rb when cnd is 1, and dst_e=15 when cnd is 0.
- R4: Opcode 3 gives no reads (both sources 15), operand A code 1, operand B zero, add, dst_e=rb, dst_m=15.
- R5: Opcode 4 reads src_a=ra, src_b=rb with no writes. Opcode 5 reads src_a=15, src_b=rb and writes dst_m=ra, dst_e=15. Both use operand A code 1, operand B code 0, add.
- R6: Opcode 6 reads ra and rb, writes dst_e=rb, uses operand codes 0/0, takes alu_fn from ifun bits [1:0], and is the only opcode that raises set_cc.
- R7: Opcodes 10 (push) and 8 (call) read src_b=4 and write dst_e=4 with operand A code 3 (-8), operand B code 0, add, dst_m=15. Push reads src_a=ra and call reads src_a=15.
- R8: Opcodes 11 (pop) and 9 (return) read src_a=src_b=4 and write dst_e=4 with operand A code 2 (+8), operand B code 0, add. Pop writes dst_m=ra and return writes dst_m=15.
- R9: Opcodes 0, 1, 7 and 12 to 15 give all four ports 15, set_cc=0, and the idle ALU word of R1.
- R10: cnd has no effect on any output except dst_e for opcode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is present this cycle |
| icode | input | 4 | Opcode |
| ifun | input | 4 | Function / condition code |
| ra | input | 4 | First register field |
| rb | input | 4 | Second register field |
| cnd | input | 1 | Evaluated condition for the instruction |
| out_valid | output | 1 | Registered selection is valid |
| src_a | output | 4 | Read port A index (15 = none) |
| src_b | output | 4 | Read port B index (15 = none) |
| dst_e | output | 4 | ALU-result write index (15 = none) |
| dst_m | output | 4 | Memory-value write index (15 = none) |
| alu_a_sel | output | 2 | Operand A choice |
| alu_b_sel | output | 1 | Operand B choice |
| alu_fn | output | 2 | ALU operation |
| set_cc | output | 1 | Update condition codes |

## Verification
The assertions assume that icode, ra, rb and cnd are known, non-X values whenever in_valid is high. They also assume that cnd is already final in the cycle it is sampled. The stimulus changes inputs only on falling edges and never leaves a field undriven. It sweeps every opcode against both condition values and varies the register fields, including fields equal to the stack index and to 15, so the stack substitution is exercised where it collides with a named register.

// File: rtl/rsel_pkg.sv
// Shared encodings for the register port and ALU operand selector.
// Assumes a 4-bit opcode space; index values are parameters of the modules.
package rsel_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_HALT  = 4'h0,
        OPC_NOP   = 4'h1,
        OPC_MOVE  = 4'h2,
        OPC_IMOV  = 4'h3,
        OPC_STORE = 4'h4,
        OPC_LOAD  = 4'h5,
        OPC_ARITH = 4'h6,
        OPC_JUMP  = 4'h7,
        OPC_CALL  = 4'h8,
        OPC_RET   = 4'h9,
        OPC_PUSH  = 4'hA,
        OPC_POP   = 4'hB
    } opc_e;

    typedef enum logic [1:0] {
        OPA_READ  = 2'd0,
        OPA_CONST = 2'd1,
        OPA_PLUS8 = 2'd2,
        OPA_MIN8  = 2'd3
    } opa_e;

    typedef enum logic {
        OPB_READ = 1'b0,
        OPB_ZERO = 1'b1
    } opb_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } fn_e;

endpackage

// File: rtl/rsel_src.sv
// Read-port index selection. Substitutes the stack index for stack
// instructions and the "none" index where no operand is read.
// Assumes icode is known whenever the result is consumed.
module rsel_src #(
    parameter int REG_W    = 4,
    parameter int SP_IDX   = 4,
    parameter int NONE_IDX = 15
) (
    input  logic [rsel_pkg::OPC_W-1:0] icode,
    input  logic [REG_W-1:0]           ra,
    input  logic [REG_W-1:0]           rb,
    output logic [REG_W-1:0]           src_a,
    output logic [REG_W-1:0]           src_b
);
    import rsel_pkg::*;

    localparam logic [REG_W-1:0] SP   = REG_W'(SP_IDX);
    localparam logic [REG_W-1:0] NONE = REG_W'(NONE_IDX);

    // Choose the register index for each of the two read ports.
    always_comb begin
        src_a = NONE;
        src_b = NONE;
        case (opc_e'(icode))
            OPC_MOVE:  src_a = ra;
            OPC_STORE: begin src_a = ra; src_b = rb; end
            OPC_LOAD:  src_b = rb;
            OPC_ARITH: begin src_a = ra; src_b = rb; end
            OPC_PUSH:  begin src_a = ra; src_b = SP; end
            OPC_CALL:  src_b = SP;
            OPC_POP,
            OPC_RET:   begin src_a = SP; src_b = SP; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/rsel_dst.sv
// Write-port index selection for the ALU-result and memory-value ports.
// Gates the conditional move by cnd. Assumes cnd is final when sampled.
module rsel_dst #(
    parameter int REG_W    = 4,
    parameter int SP_IDX   = 4,
    parameter int NONE_IDX = 15
) (
    input  logic [rsel_pkg::OPC_W-1:0] icode,
    input  logic [REG_W-1:0]           ra,
    input  logic [REG_W-1:0]           rb,
    input  logic                       cnd,
    output logic [REG_W-1:0]           dst_e,
    output logic [REG_W-1:0]           dst_m
);
    import rsel_pkg::*;

    localparam logic [REG_W-1:0] SP   = REG_W'(SP_IDX);
    localparam logic [REG_W-1:0] NONE = REG_W'(NONE_IDX);

    // Choose the register index for each of the two write ports.
    always_comb begin
        dst_e = NONE;
        dst_m = NONE;
        case (opc_e'(icode))
            OPC_MOVE:  dst_e = cnd ? rb : NONE;
            OPC_IMOV:  dst_e = rb;
            OPC_LOAD:  dst_m = ra;
            OPC_ARITH: dst_e = rb;
            OPC_PUSH,
            OPC_CALL,
            OPC_RET:   dst_e = SP;
            OPC_POP:   begin dst_e = SP; dst_m = ra; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/rsel_alu.sv
// ALU operand and operation selection, plus the condition-code update
// strobe. Only the arithmetic opcode takes its function from ifun.
module rsel_alu (
    input  logic [rsel_pkg::OPC_W-1:0] icode,
    input  logic [3:0]                 ifun,
    output rsel_pkg::opa_e             a_sel,
    output rsel_pkg::opb_e             b_sel,
    output rsel_pkg::fn_e              fn,
    output logic                       set_cc
);
    import rsel_pkg::*;

    // Choose operands and operation for the decoded opcode.
    always_comb begin
        a_sel  = OPA_READ;
        b_sel  = OPB_ZERO;
        fn     = FN_ADD;
        set_cc = 1'b0;
        case (opc_e'(icode))
            OPC_MOVE:  begin a_sel = OPA_READ;  b_sel = OPB_ZERO; end
            OPC_IMOV:  begin a_sel = OPA_CONST; b_sel = OPB_ZERO; end
            OPC_STORE,
            OPC_LOAD:  begin a_sel = OPA_CONST; b_sel = OPB_READ; end
            OPC_ARITH: begin
                a_sel  = OPA_READ;
                b_sel  = OPB_READ;
                fn     = fn_e'(ifun[1:0]);
                set_cc = 1'b1;
            end
            OPC_PUSH,
            OPC_CALL:  begin a_sel = OPA_MIN8;  b_sel = OPB_READ; end
            OPC_POP,
            OPC_RET:   begin a_sel = OPA_PLUS8; b_sel = OPB_READ; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/rsel_top.sv
// Register port and ALU operand selector. Combines the read, write and
// ALU selections and presents them through one output register stage
// (OUT_REG=1) or directly (OUT_REG=0). Idle cycles present "no access".
module rsel_top #(
    parameter int REG_W    = 4,
    parameter int SP_IDX   = 4,
    parameter int NONE_IDX = 15,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       icode,
    input  logic [3:0]       ifun,
    input  logic [REG_W-1:0] ra,
    input  logic [REG_W-1:0] rb,
    input  logic             cnd,
    output logic             out_valid,
    output logic [REG_W-1:0] src_a,
    output logic [REG_W-1:0] src_b,
    output logic [REG_W-1:0] dst_e,
    output logic [REG_W-1:0] dst_m,
    output logic [1:0]       alu_a_sel,
    output logic             alu_b_sel,
    output logic [1:0]       alu_fn,
    output logic             set_cc
);
    import rsel_pkg::*;

    localparam logic [REG_W-1:0] NONE = REG_W'(NONE_IDX);

    logic [REG_W-1:0] c_src_a, c_src_b, c_dst_e, c_dst_m;
    opa_e             c_a_sel;
    opb_e             c_b_sel;
    fn_e              c_fn;
    logic             c_cc;

    rsel_src #(.REG_W(REG_W), .SP_IDX(SP_IDX), .NONE_IDX(NONE_IDX)) u_src (
        .icode(icode), .ra(ra), .rb(rb), .src_a(c_src_a), .src_b(c_src_b)
    );

    rsel_dst #(.REG_W(REG_W), .SP_IDX(SP_IDX), .NONE_IDX(NONE_IDX)) u_dst (
        .icode(icode), .ra(ra), .rb(rb), .cnd(cnd),
        .dst_e(c_dst_e), .dst_m(c_dst_m)
    );

    rsel_alu u_alu (
        .icode(icode), .ifun(ifun),
        .a_sel(c_a_sel), .b_sel(c_b_sel), .fn(c_fn), .set_cc(c_cc)
    );

    // Next-stage control word: real selection or the idle word.
    logic             n_valid, n_b, n_cc;
    logic [REG_W-1:0] n_sa, n_sb, n_de, n_dm;
    logic [1:0]       n_a, n_fn;

    // Force the idle word when no instruction is present.
    always_comb begin
        n_valid = in_valid;
        n_sa    = in_valid ? c_src_a : NONE;
        n_sb    = in_valid ? c_src_b : NONE;
        n_de    = in_valid ? c_dst_e : NONE;
        n_dm    = in_valid ? c_dst_m : NONE;
        n_a     = in_valid ? c_a_sel : OPA_READ;
        n_b     = in_valid ? c_b_sel : OPB_ZERO;
        n_fn    = in_valid ? c_fn    : FN_ADD;
        n_cc    = in_valid & c_cc;
    end

    generate
        if (OUT_REG) begin : g_reg
            // Capture the control word; reset loads the idle word.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    src_a     <= NONE;
                    src_b     <= NONE;
                    dst_e     <= NONE;
                    dst_m     <= NONE;
                    alu_a_sel <= OPA_READ;
                    alu_b_sel <= OPB_ZERO;
                    alu_fn    <= FN_ADD;
                    set_cc    <= 1'b0;
                end else begin
                    out_valid <= n_valid;
                    src_a     <= n_sa;
                    src_b     <= n_sb;
                    dst_e     <= n_de;
                    dst_m     <= n_dm;
                    alu_a_sel <= n_a;
                    alu_b_sel <= n_b;
                    alu_fn    <= n_fn;
                    set_cc    <= n_cc;
                end
            end
        end else begin : g_comb
            // Pass the control word straight through.
            always_comb begin
                out_valid = n_valid;
                src_a     = n_sa;
                src_b     = n_sb;
                dst_e     = n_de;
                dst_m     = n_dm;
                alu_a_sel = n_a;
                alu_b_sel = n_b;
                alu_fn    = n_fn;
                set_cc    = n_cc;
            end
        end
    endgenerate
endmodule

// File: rtl/rsel_chk.sv
// Checker for rsel_top with its output register stage enabled (OUT_REG=1).
// Relates inputs at one edge to the registered outputs at the next.
module rsel_chk #(
    parameter int REG_W    = 4,
    parameter int SP_IDX   = 4,
    parameter int NONE_IDX = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       icode,
    input logic [REG_W-1:0] ra,
    input logic             cnd,
    input logic             out_valid,
    input logic [REG_W-1:0] src_a,
    input logic [REG_W-1:0] src_b,
    input logic [REG_W-1:0] dst_e,
    input logic [REG_W-1:0] dst_m,
    input logic [1:0]       alu_a_sel,
    input logic             set_cc
);
    localparam logic [REG_W-1:0] SP   = REG_W'(SP_IDX);
    localparam logic [REG_W-1:0] NONE = REG_W'(NONE_IDX);

    // R2: an empty cycle yields the idle port word
    p_idle_ports_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && src_a == NONE && src_b == NONE &&
                       dst_e == NONE && dst_m == NONE && !set_cc));

    p_move_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && icode == 4'h2 && !cnd) |=> (dst_e == NONE));

    p_move_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && icode == 4'h2 && cnd) |=> (dst_e != NONE || src_a == NONE));

    p_cc_only_arith_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && icode != 4'h6) |=> !set_cc);

    p_cc_arith_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && icode == 4'h6) |=> set_cc);

    p_stack_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (icode == 4'h8 || icode == 4'hA)) |=>
        (src_b == SP && dst_e == SP && alu_a_sel == 2'd3));

    p_stack_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (icode == 4'h9 || icode == 4'hB)) |=>
        (src_a == SP && src_b == SP && dst_e == SP && alu_a_sel == 2'd2));

    p_pop_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && icode == 4'hB) |=> (dst_m == $past(ra)));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (icode == 4'h0 || icode == 4'h1 || icode == 4'h7 || icode >= 4'hC)) |=>
        (dst_e == NONE && dst_m == NONE && src_a == NONE && src_b == NONE));
endmodule

bind rsel_top rsel_chk #(.REG_W(REG_W), .SP_IDX(SP_IDX), .NONE_IDX(NONE_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .icode(icode), .ra(ra),
    .cnd(cnd), .out_valid(out_valid), .src_a(src_a), .src_b(src_b),
    .dst_e(dst_e), .dst_m(dst_m), .alu_a_sel(alu_a_sel), .set_cc(set_cc)
);

// File: tb/sim_rsel_top.sv
// Scoreboard bench: the driver pushes expected control words, the monitor
// compares them five ns after the rising edge that registers them.
module sim_rsel_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] icode = 4'h0, ifun = 4'h0, ra = 4'h0, rb = 4'h0;
    logic       cnd = 1'b0;
    logic       out_valid, alu_b_sel, set_cc;
    logic [3:0] src_a, src_b, dst_e, dst_m;
    logic [1:0] alu_a_sel, alu_fn;

    always #10 clk = ~clk;

    rsel_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .icode(icode),
        .ifun(ifun), .ra(ra), .rb(rb), .cnd(cnd), .out_valid(out_valid),
        .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_fn(alu_fn),
        .set_cc(set_cc)
    );

    // {valid, sa, sb, de, dm, a, b, fn, cc} = 24 bits
    logic [23:0] exp_q[$];
    string       tag_q[$];
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    function automatic logic [23:0] pack(logic v, logic [3:0] sa, logic [3:0] sb,
                                         logic [3:0] de, logic [3:0] dm, logic [1:0] a,
                                         logic b, logic [1:0] fn, logic cc);
        return {v, sa, sb, de, dm, a, b, fn, cc, 1'b0};
    endfunction

    // Expected word written from the requirement text.
    function automatic logic [23:0] model(logic v, logic [3:0] op, logic [3:0] fu,
                                          logic [3:0] a, logic [3:0] b, logic c);
        if (!v) return pack(0, 15, 15, 15, 15, 0, 1, 0, 0);
        case (op)
            4'h2: return pack(1, a, 15, c ? b : 4'd15, 15, 0, 1, 0, 0);
            4'h3: return pack(1, 15, 15, b, 15, 1, 1, 0, 0);
            4'h4: return pack(1, a, b, 15, 15, 1, 0, 0, 0);
            4'h5: return pack(1, 15, b, 15, a, 1, 0, 0, 0);
            4'h6: return pack(1, a, b, b, 15, 0, 0, fu[1:0], 1);
            4'hA: return pack(1, a, 4, 4, 15, 3, 0, 0, 0);
            4'h8: return pack(1, 15, 4, 4, 15, 3, 0, 0, 0);
            4'hB: return pack(1, 4, 4, 4, a, 2, 0, 0, 0);
            4'h9: return pack(1, 4, 4, 4, 15, 2, 0, 0, 0);
            default: return pack(1, 15, 15, 15, 15, 0, 1, 0, 0);
        endcase
    endfunction

    function automatic logic [23:0] actual();
        return pack(out_valid, src_a, src_b, dst_e, dst_m, alu_a_sel, alu_b_sel, alu_fn, set_cc);
    endfunction

    task automatic drive(logic v, logic [3:0] op, logic [3:0] fu, logic [3:0] a,
                         logic [3:0] b, logic c, string tag);
        @(negedge clk);
        in_valid = v; icode = op; ifun = fu; ra = a; rb = b; cnd = c;
        exp_q.push_back(model(v, op, fu, a, b, c));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the oldest expectation after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (actual() !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, actual(), e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        n_cmp++;
        if (actual() !== pack(0, 15, 15, 15, 15, 0, 1, 0, 0)) begin
            n_bad++;
            $display("FAIL R1: actual %h expected %h", actual(), pack(0, 15, 15, 15, 15, 0, 1, 0, 0));
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(1, 4'h2, 0, 1, 2, 1, "R3 move pass");
        drive(1, 4'h2, 3, 1, 2, 0, "R3 move fail");
        drive(0, 4'h6, 0, 3, 3, 1, "R2 idle");
        drive(1, 4'h3, 0, 15, 7, 0, "R4 imov");
        drive(1, 4'h4, 0, 5, 6, 1, "R5 store");
        drive(1, 4'h5, 0, 8, 9, 0, "R5 load");
        for (int f = 0; f < 4; f++) drive(1, 4'h6, 4'(f), 2, 13, 0, "R6 arith");
        drive(1, 4'hA, 0, 3, 15, 0, "R7 push");
        drive(1, 4'h8, 0, 0, 0, 1, "R7 call");
        drive(1, 4'hB, 0, 5, 15, 0, "R8 pop");
        drive(1, 4'hB, 0, 4, 15, 1, "R8 pop sp");
        drive(1, 4'h9, 0, 0, 0, 0, "R8 ret");
        drive(1, 4'h0, 0, 1, 2, 0, "R9 halt");
        drive(1, 4'h1, 0, 1, 2, 1, "R9 nop");
        drive(1, 4'h7, 3, 0, 0, 1, "R9 jump");
        drive(1, 4'hC, 0, 1, 2, 1, "R9 unused C");
        drive(1, 4'hF, 0, 1, 2, 0, "R9 unused F");
        for (int op = 0; op < 16; op++)
            for (int c = 0; c < 2; c++)
                drive(1, 4'(op), 4'(op), 4'(op + 3), 4'(9 - op), c[0], "R10 cnd sweep");
        drive(0, 0, 0, 0, 0, 0, "R2 idle end");
        while (exp_q.size() > 0) @(posedge clk);
        #10;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule